// File: doc/BRIEF.md
# Transmit Path Reset Sequencer

This controller brings the transmit half of a serial transceiver out of reset after power-up. It runs on a free-running controller clock. From a power-on reset request it drives four reset outputs in a fixed order: a reset for the calibration manager, a power-down for the transmit PLL, a reset for the TX analog section and a reset for the TX digital section. Every minimum hold time is a clock-cycle count. The PLL power-down time is given in nanoseconds and is turned into cycles from the clock frequency parameter.

The release order depends on a static option input that tells whether the PLL is calibrated. When the option is set, the PLL is powered up before the calibration manager leaves reset, so the PLL has power while it is calibrated. When the option is clear, the power-down is released at or after the manager reset.

The lock and calibration-busy inputs are asynchronous. Each passes through a synchronizer of two or more flops. The digital reset is released only after lock is present, calibration is idle and the PLL is powered, and all three have held without a break for a settling window. A break in any of them restarts the window. The two status events may arrive in either order, and lock may chatter during calibration. Once the block is ready, losing lock or seeing calibration become busy again puts the digital reset back on, and the block waits for the gating conditions once more.

Top module: `tx_reset_sequencer`

## Requirements
- R1: From the first clock after `por_req` is sampled high, and for as long as it stays high, `mgmt_rst`, `pll_pd`, `tx_ana_rst` and `tx_dig_rst` are all 1 and `ready` is 0. This holds whatever state the block was in before.
- R2: Rising edges are counted from the first one at which `por_req` is sampled low, which is edge 1. `mgmt_rst` goes to 0 at edge PD_CYC+MGMT_CYC when `pll_cal_en`=1, and at edge MGMT_CYC when `pll_cal_en`=0. Including the reset-request cycle, it is held for at least two cycles.
- R3: PD_CYC is the smallest integer with PD_CYC*1000 >= PD_NS*CLK_MHZ. Counting edges as in R2, `pll_pd` goes to 0 at edge PD_CYC when `pll_cal_en`=1, and at edge max(PD_CYC, MGMT_CYC) when `pll_cal_en`=0.
- R4: With `pll_cal_en`=1, `pll_pd` is released exactly MGMT_CYC cycles before `mgmt_rst`. With `pll_cal_en`=0, `pll_pd` is released in the same cycle as `mgmt_rst` or later.
- R5: `tx_ana_rst` is released in the same cycle as `pll_pd`.
- R6: The resets are nested. While `pll_pd`=1, `tx_ana_rst`=1. While `tx_ana_rst`=1, `tx_dig_rst`=1.
- R7: `tx_dig_rst` goes to 0 only after three conditions have held without a break for at least SETTLE_CYC cycles: `pll_locked`=1, `tx_cal_busy`=0 and `pll_pd`=0. A break restarts the count.
- R8: The release described in R7 happens whether `tx_cal_busy` falls before, after or together with the rise of `pll_locked`. It happens within SETTLE_CYC+6 cycles of the point where all three conditions are true.
- R9: Pulses on `pll_locked` while `tx_cal_busy`=1 never release `tx_dig_rst`. Once lock is steady and calibration is idle, the release follows as in R8.
- R10: `ready` is 1 exactly when `tx_dig_rst` is 0.
- R11: Suppose that, while `ready`=1, `pll_locked` falls or `tx_cal_busy` rises, with the input changed between clock edges. Then `tx_dig_rst` stays 0 up to the second rising edge after the change and is 1 after the third. Settling then starts again from the beginning.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running controller clock |
| por_req | input | 1 | Power-on reset request, active high, sampled on `clk` |
| pll_cal_en | input | 1 | 1 when the PLL is calibrated; held constant through a sequence |
| pll_locked | input | 1 | Asynchronous PLL lock status |
| tx_cal_busy | input | 1 | Asynchronous TX calibration busy status |
| mgmt_rst | output | 1 | Reset to the calibration manager |
| pll_pd | output | 1 | Transmit PLL power-down |
| tx_ana_rst | output | 1 | TX analog section reset |
| tx_dig_rst | output | 1 | TX digital section reset |
| ready | output | 1 | Transmit path is out of reset |

## Verification
The hardest situation to reach is lock chattering during calibration combined with an arbitrary order and spacing of the lock and busy events. Only this combination shows whether the settling window restarts on every break and never lets a short good run through. The bench draws lock and busy arrival times from a seeded generator. It scatters random one-cycle lock dropouts across the busy interval, and it adds directed cases where both events come before the PLL is powered, or arrive in opposite orders. After each release it forces a short loss of lock or a return of busy, and checks the exact cycle at which the digital reset returns.

// File: rtl/txrs_pkg.sv
package txrs_pkg;

  typedef enum logic [2:0] {
    ST_MGMT_RST   = 3'd0,
    ST_PLL_PD     = 3'd1,
    ST_WAIT_GATES = 3'd2,
    ST_SETTLE     = 3'd3,
    ST_READY      = 3'd4
  } txrs_state_e;

  // nanoseconds to clock cycles, rounded up
  function automatic int ns_to_cycles(input int ns, input int mhz);
    return (ns * mhz + 999) / 1000;
  endfunction

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // bits needed to count up to n inclusive, plus one spare
  function automatic int count_width(input int n);
    return $clog2(n + 1) + 1;
  endfunction

endpackage

// File: rtl/txrs_sync.sv
module txrs_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [STAGES-1:0][W-1:0] stg;

  initial begin
    if (STAGES < 2) $error("txrs_sync needs at least two stages");
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= din;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/txrs_count.sv
module txrs_count #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         clr,
  input  logic         en,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (clr)                 q <= '0;
    else if (en && q != '1)  q <= q + 1'b1;
  end
endmodule

// File: rtl/txrs_fsm.sv
module txrs_fsm
  import txrs_pkg::*;
#(
  parameter int PD_CYC     = 100,
  parameter int MGMT_CYC   = 2,
  parameter int SETTLE_CYC = 16,
  parameter int CW         = 8
) (
  input  logic          clk,
  input  logic          por_req,
  input  logic          cal_en,
  input  logic          lock_s,
  input  logic          busy_s,
  input  logic [CW-1:0] cnt,
  output logic          cnt_clr,
  output logic          cnt_en,
  output logic          mgmt_rst,
  output logic          pll_pd,
  output logic          tx_ana_rst,
  output logic          tx_dig_rst,
  output logic          ready
);
  localparam int PD_END_NOCAL = max_int(PD_CYC, MGMT_CYC);
  localparam logic [CW-1:0] MG_LAST_CAL   = CW'(PD_CYC + MGMT_CYC - 1);
  localparam logic [CW-1:0] MG_LAST_NOCAL = CW'(MGMT_CYC - 1);
  localparam logic [CW-1:0] PD_LIM_CAL    = CW'(PD_CYC);
  localparam logic [CW-1:0] PD_LIM_NOCAL  = CW'(PD_END_NOCAL);
  localparam logic [CW-1:0] SETTLE_LAST   = CW'(SETTLE_CYC - 1);

  txrs_state_e state, nxt;

  // named internal events
  logic gate_ok;     // all release conditions present this cycle
  logic mg_done;     // management hold window complete
  logic pd_done;     // no-cal power-down window complete
  logic settle_done; // settling window complete
  logic pd_cond;     // power-down still required

  assign mg_done     = cnt >= (cal_en ? MG_LAST_CAL : MG_LAST_NOCAL);
  assign pd_done     = cnt >= (PD_LIM_NOCAL - 1'b1);
  assign settle_done = cnt >= SETTLE_LAST;

  always_comb begin
    pd_cond = 1'b0;
    case (state)
      ST_MGMT_RST: pd_cond = cal_en ? (cnt < PD_LIM_CAL) : 1'b1;
      ST_PLL_PD:   pd_cond = cnt < PD_LIM_NOCAL;
      default:     pd_cond = 1'b0;
    endcase
  end

  assign gate_ok = lock_s && !busy_s && !pll_pd;

  always_comb begin
    nxt = state;
    case (state)
      ST_MGMT_RST:   if (mg_done) nxt = cal_en ? ST_WAIT_GATES : ST_PLL_PD;
      ST_PLL_PD:     if (pd_done) nxt = ST_WAIT_GATES;
      ST_WAIT_GATES: if (gate_ok) nxt = ST_SETTLE;
      ST_SETTLE: begin
        if (!gate_ok)         nxt = ST_WAIT_GATES;
        else if (settle_done) nxt = ST_READY;
      end
      ST_READY:      if (!gate_ok) nxt = ST_WAIT_GATES;
      default:       nxt = ST_MGMT_RST;
    endcase
  end

  always_ff @(posedge clk) begin
    if (por_req) state <= ST_MGMT_RST;
    else         state <= nxt;
  end

  // the counter runs through both power-down phases without a restart
  assign cnt_clr = por_req || (nxt == ST_WAIT_GATES) ||
                   (state == ST_WAIT_GATES) || (state == ST_READY);
  assign cnt_en  = !cnt_clr;

  assign mgmt_rst   = (state == ST_MGMT_RST);
  assign pll_pd     = pd_cond;
  assign tx_ana_rst = (state == ST_MGMT_RST || state == ST_PLL_PD) && pd_cond;
  assign tx_dig_rst = (state != ST_READY);
  assign ready      = (state == ST_READY);

  // ---------------- checker run-length counters ----------------
  logic [CW-1:0] mg_run, pd_run, gate_run;
  always_ff @(posedge clk) begin
    if (por_req) begin
      mg_run <= '0; pd_run <= '0; gate_run <= '0;
    end else begin
      mg_run   <= mgmt_rst ? ((mg_run   == '1) ? mg_run   : mg_run   + 1'b1) : '0;
      pd_run   <= pll_pd   ? ((pd_run   == '1) ? pd_run   : pd_run   + 1'b1) : '0;
      gate_run <= gate_ok  ? ((gate_run == '1) ? gate_run : gate_run + 1'b1) : '0;
    end
  end

  // R1: a reset request forces every reset on at the next clock
  a_r1_por_all_reset: assert property (@(posedge clk)
    por_req |=> (mgmt_rst && pll_pd && tx_ana_rst && tx_dig_rst && !ready));

  // R2: management reset meets its minimum hold
  a_r2_mgmt_min_hold: assert property (@(posedge clk) disable iff (por_req)
    $fell(mgmt_rst) |-> (mg_run >= CW'(MGMT_CYC)));

  // R3: power-down meets its minimum hold
  a_r3_pd_min_hold: assert property (@(posedge clk) disable iff (por_req)
    $fell(pll_pd) |-> (pd_run >= CW'(PD_CYC)));

  // R4: option-dependent order of power-down and management release
  a_r4_cal_order: assert property (@(posedge clk) disable iff (por_req)
    (cal_en && $fell(mgmt_rst)) |-> !pll_pd);
  a_r4_nocal_order: assert property (@(posedge clk) disable iff (por_req)
    (!cal_en && $fell(pll_pd)) |-> !mgmt_rst);

  // R6: analog reset implies digital reset
  a_r6_nesting: assert property (@(posedge clk) disable iff (por_req)
    tx_ana_rst |-> tx_dig_rst);

  // R7: digital release only after a full unbroken settling window
  a_r7_settle_window: assert property (@(posedge clk) disable iff (por_req)
    $fell(tx_dig_rst) |-> (gate_run >= CW'(SETTLE_CYC)));

  // R11: loss of lock while ready reasserts the digital reset
  a_r11_lock_loss: assert property (@(posedge clk) disable iff (por_req)
    (ready && !lock_s) |=> tx_dig_rst);

endmodule

// File: rtl/tx_reset_sequencer.sv
module tx_reset_sequencer
  import txrs_pkg::*;
#(
  parameter int CLK_MHZ     = 100,
  parameter int PD_NS       = 1000,
  parameter int MGMT_CYC    = 2,
  parameter int SETTLE_CYC  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic por_req,
  input  logic pll_cal_en,
  input  logic pll_locked,
  input  logic tx_cal_busy,
  output logic mgmt_rst,
  output logic pll_pd,
  output logic tx_ana_rst,
  output logic tx_dig_rst,
  output logic ready
);
  localparam int PD_CYC = ns_to_cycles(PD_NS, CLK_MHZ);
  localparam int CW     = count_width(PD_CYC + MGMT_CYC + SETTLE_CYC);

  initial begin
    if (MGMT_CYC < 2)   $error("MGMT_CYC must be at least 2");
    if (SETTLE_CYC < 1) $error("SETTLE_CYC must be at least 1");
  end

  logic [1:0]    status_s;   // {busy, lock}
  logic          lock_s, busy_s;
  logic [CW-1:0] cnt;
  logic          cnt_clr, cnt_en;

  // lock resets to absent, busy resets to busy
  txrs_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b10)) u_sync (
    .clk (clk),
    .rst (por_req),
    .din ({tx_cal_busy, pll_locked}),
    .dout(status_s)
  );
  assign lock_s = status_s[0];
  assign busy_s = status_s[1];

  txrs_count #(.W(CW)) u_cnt (
    .clk(clk),
    .clr(cnt_clr),
    .en (cnt_en),
    .q  (cnt)
  );

  txrs_fsm #(
    .PD_CYC    (PD_CYC),
    .MGMT_CYC  (MGMT_CYC),
    .SETTLE_CYC(SETTLE_CYC),
    .CW        (CW)
  ) u_fsm (
    .clk       (clk),
    .por_req   (por_req),
    .cal_en    (pll_cal_en),
    .lock_s    (lock_s),
    .busy_s    (busy_s),
    .cnt       (cnt),
    .cnt_clr   (cnt_clr),
    .cnt_en    (cnt_en),
    .mgmt_rst  (mgmt_rst),
    .pll_pd    (pll_pd),
    .tx_ana_rst(tx_ana_rst),
    .tx_dig_rst(tx_dig_rst),
    .ready     (ready)
  );
endmodule

// File: tb/sim_tx_reset_sequencer.sv
module sim_tx_reset_sequencer;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_MHZ    = 100;
  localparam int PD_NS      = 1000;
  localparam int MGMT_CYC   = 2;
  localparam int SETTLE_CYC = 16;

  logic clk = 1'b0;
  logic por_req = 1'b1, pll_cal_en = 1'b0, pll_locked = 1'b0, tx_cal_busy = 1'b1;
  logic mgmt_rst, pll_pd, tx_ana_rst, tx_dig_rst, ready;

  int total = 0, bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tx_reset_sequencer #(
    .CLK_MHZ(CLK_MHZ), .PD_NS(PD_NS), .MGMT_CYC(MGMT_CYC),
    .SETTLE_CYC(SETTLE_CYC), .SYNC_STAGES(2)
  ) u0 (
    .clk(clk), .por_req(por_req), .pll_cal_en(pll_cal_en),
    .pll_locked(pll_locked), .tx_cal_busy(tx_cal_busy),
    .mgmt_rst(mgmt_rst), .pll_pd(pll_pd), .tx_ana_rst(tx_ana_rst),
    .tx_dig_rst(tx_dig_rst), .ready(ready)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // smallest cycle count covering the power-down time
  function automatic int bench_pd_cycles();
    int c = 0;
    while (c * 1000 < PD_NS * CLK_MHZ) c++;
    return c;
  endfunction

  function automatic int exp_mgmt_low(input bit en);
    return en ? bench_pd_cycles() + MGMT_CYC : MGMT_CYC;
  endfunction

  function automatic int exp_pd_low(input bit en);
    int p = bench_pd_cycles();
    if (en) return p;
    return (p > MGMT_CYC) ? p : MGMT_CYC;
  endfunction

  task automatic run_trial(input bit en, input int t_lock, input int t_busy,
                           input bit glitch, input int loss_kind);
    int k = 0, mg_low = -1, pd_low = -1, ana_low = -1, consec = 0, horizon;
    bit hier_ok = 1, early_ok = 1, rdy_ok = 1;
    por_req = 1'b1;
    @(negedge clk);
    check(mgmt_rst && pll_pd && tx_ana_rst && tx_dig_rst && !ready,
          "R1 reset next clock", {mgmt_rst, pll_pd, tx_ana_rst, tx_dig_rst, ready}, 5'b11110);
    pll_locked = 1'b0; tx_cal_busy = 1'b1; pll_cal_en = en;
    repeat (3) @(negedge clk);
    check(mgmt_rst && pll_pd && tx_ana_rst && tx_dig_rst && !ready,
          "R1 reset held", {mgmt_rst, pll_pd, tx_ana_rst, tx_dig_rst, ready}, 5'b11110);
    por_req = 1'b0;
    horizon = ((t_lock > t_busy) ? t_lock : t_busy) + exp_pd_low(en) + SETTLE_CYC + 20;
    while (k < horizon) begin
      @(negedge clk);
      k++;
      if (mg_low < 0 && !mgmt_rst)   mg_low = k;
      if (pd_low < 0 && !pll_pd)     pd_low = k;
      if (ana_low < 0 && !tx_ana_rst) ana_low = k;
      if ((pll_pd && !tx_ana_rst) || (tx_ana_rst && !tx_dig_rst)) hier_ok = 0;
      if (ready == tx_dig_rst) rdy_ok = 0;
      if (pd_low >= 0 && pll_locked && !tx_cal_busy) consec++;
      else consec = 0;
      if (!tx_dig_rst && consec < SETTLE_CYC) early_ok = 0;
      tx_cal_busy = (k < t_busy);
      pll_locked  = (k >= t_lock);
      if (glitch && k >= t_lock && k < t_busy && ($urandom % 3 == 0)) pll_locked = 1'b0;
    end
    check(mg_low == exp_mgmt_low(en), "R2 mgmt release edge", mg_low, exp_mgmt_low(en));
    check(pd_low == exp_pd_low(en), "R3 pd release edge", pd_low, exp_pd_low(en));
    check(ana_low == pd_low, "R5 analog with pd", ana_low, pd_low);
    if (en) check(pd_low + MGMT_CYC == mg_low, "R4 cal order", pd_low + MGMT_CYC, mg_low);
    else    check(pd_low >= mg_low, "R4 nocal order", pd_low, mg_low);
    check(hier_ok, "R6 nesting", hier_ok, 1);
    check(early_ok, "R7 settle window", early_ok, 1);
    check(rdy_ok, "R10 ready vs digital", rdy_ok, 1);
    if (glitch) check(ready == 1'b1, "R9 ready after chatter", ready, 1);
    else        check(ready == 1'b1, "R8 ready any order", ready, 1);

    if (loss_kind != 0) begin
      if (loss_kind == 1) pll_locked = 1'b0;
      else                tx_cal_busy = 1'b1;
      @(negedge clk);
      if (loss_kind == 1) pll_locked = 1'b1;
      check(!tx_dig_rst, "R11 not before sync edge1", tx_dig_rst, 0);
      @(negedge clk);
      tx_cal_busy = 1'b0;
      check(!tx_dig_rst, "R11 not before sync edge2", tx_dig_rst, 0);
      @(negedge clk);
      check(tx_dig_rst && !ready, "R11 reassert edge3", tx_dig_rst, 1);
      repeat (SETTLE_CYC - 2) @(negedge clk);
      check(tx_dig_rst, "R11 settle restarted", tx_dig_rst, 1);
      repeat (10) @(negedge clk);
      check(ready && !tx_dig_rst, "R11 recovered", ready, 1);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      check(0, "watchdog expired", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1f2e3d4c));
    repeat (2) @(negedge clk);
    // R1 reset state from time zero
    check(mgmt_rst && pll_pd && tx_ana_rst && tx_dig_rst && !ready,
          "R1 initial reset", {mgmt_rst, pll_pd, tx_ana_rst, tx_dig_rst, ready}, 5'b11110);
    // directed corners
    run_trial(1'b1,  50, 120, 1'b0, 1);  // R8 lock first
    run_trial(1'b0, 120,  50, 1'b0, 2);  // R8 busy first
    run_trial(1'b1,  10,  10, 1'b0, 1);  // both before pd release
    run_trial(1'b0,  30, 150, 1'b1, 1);  // R9 chatter
    run_trial(1'b1,  40, 160, 1'b1, 2);  // R9 chatter, cal
    run_trial(1'b0, 200, 200, 1'b0, 0);  // simultaneous, late
    // random trials
    for (int n = 0; n < 10; n++) begin
      bit en = 1'($urandom % 2);
      int tl = 5 + int'($urandom % 200);
      int tb = 5 + int'($urandom % 200);
      bit gl = 1'($urandom % 2);
      int lk = 1 + int'($urandom % 2);
      run_trial(en, tl, tb, gl, lk);
    end
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule